// File: doc/BRIEF.md
# Packed Lane Add/Subtract Datapath

This block treats a 64-bit operand pair as a set of packed lanes and adds or subtracts them lane by lane. The lane width is 8, 16 or 32 bits, chosen per operation. No carry or borrow ever crosses from one lane into the next.

Each lane's raw result passes through one of five result policies: plain wrap-around, signed halving, unsigned halving, signed clamping or unsigned clamping. A crossed mode takes the lanes in neighbouring pairs. Each lane of the first operand is combined with the other lane of its pair in the second operand, and one lane of the pair adds while the other subtracts.

The result is registered. A sticky flag records that some lane was clamped and stays set until an explicit clear.

Top module: `psimd_addsub`

## Requirements
- R1: `elem_sz` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Lane i occupies bits [i*W+W-1 : i*W]. No carry or borrow passes between lanes.
- R2: `policy` 0 (wrap) returns the low W bits of a+b or a-b and drops any overflow. Codes 5 to 7 behave exactly like code 0.
- R3: `policy` 1 (signed halving) and `policy` 2 (unsigned halving) form the exact (W+1)-bit sum or difference of the sign-extended or zero-extended lanes. They then shift it right by one, which rounds toward minus infinity.
- R4: `policy` 3 (signed clamping) limits each lane to the signed range of W bits. For 16-bit lanes the range is -32768 to 32767, so 0 minus 0x8000 gives 0x7FFF.
- R5: `policy` 4 (unsigned clamping) sets a lane to all ones when an add overflows and to zero when a subtract underflows.
- R6: With `crossed`=0, lane i of `in_a` meets lane i of `in_b`, and every lane adds when `sub`=0 and subtracts when `sub`=1.
- R7: With `crossed`=1, lane i of `in_a` meets lane i XOR 1 of `in_b`. The odd lane of each pair adds when `sub`=0 and subtracts when `sub`=1; the even lane does the opposite.
- R8: `out_valid` equals `in_valid` one clock later. `out_data` loads only when `in_valid` is high and otherwise holds its value.
- R9: `out_ovf` sets at the clock after any accepted operation in which a lane was clamped. It stays set until `ovf_clr` is high at a clock edge, and that clear takes priority over a new set.
- R10: After synchronous reset, `out_valid`, `out_data` and `out_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| elem_sz | input | 2 | Lane width select |
| crossed | input | 1 | Pairwise crossed lane mode |
| sub | input | 1 | Subtract select |
| policy | input | 3 | Result policy code |
| ovf_clr | input | 1 | Clear for the sticky clamp flag |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Packed registered result |
| out_ovf | output | 1 | Sticky clamp flag |

## Verification
The bench targets the signed lane minimum subtracted from zero under clamping; a design that only negates would return 0x8000 again. Halving of negative differences and unsigned halving of a borrow catch a design that drops the extra top bit or rounds toward zero, because those lanes come out off by one or with the wrong sign. Crossed-mode runs at every width expose swapped add/subtract roles or wrong partner lanes, and all-ones lanes expose carries leaking into the neighbour lane. The flag is exercised with a set and a clear in the same cycle, and strobes without valid must leave the data unchanged.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  localparam logic [2:0] POL_WRAP  = 3'd0;
  localparam logic [2:0] POL_SHALF = 3'd1;
  localparam logic [2:0] POL_UHALF = 3'd2;
  localparam logic [2:0] POL_SSAT  = 3'd3;
  localparam logic [2:0] POL_USAT  = 3'd4;
  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/psimd_lane.sv
module psimd_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          do_sub,
  input  logic [2:0]    policy,
  output logic [LW-1:0] res,
  output logic          sat
);
  import psimd_pkg::*;

  logic          sgn;
  logic [LW:0]   ea, eb, s;

  assign sgn = (policy == POL_SHALF) || (policy == POL_SSAT);
  assign ea  = {sgn & a[LW-1], a};
  assign eb  = {sgn & b[LW-1], b};
  assign s   = do_sub ? (ea - eb) : (ea + eb);

  always_comb begin
    res = s[LW-1:0];
    sat = 1'b0;
    unique case (policy)
      POL_SHALF, POL_UHALF: res = s[LW:1];
      POL_SSAT: begin
        if (s[LW] != s[LW-1]) begin
          sat = 1'b1;
          res = s[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
        end
      end
      POL_USAT: begin
        if (s[LW]) begin
          sat = 1'b1;
          res = do_sub ? '0 : '1;
        end
      end
      default: res = s[LW-1:0];
    endcase
  end

  // R5: a clamp can only come from a clamping policy
  always_comb begin
    assert_sat_policy_R5: assert (!sat || policy == POL_SSAT || policy == POL_USAT)
      else $error("clamp under non-clamping policy");
  end

  // R5: unsigned clamped add never falls below its first operand
  always_comb begin
    assert_usat_mono_R5: assert (!(policy == POL_USAT && !do_sub) || res >= a)
      else $error("unsigned clamped add shrank");
  end
endmodule

// File: rtl/psimd_group.sv
module psimd_group #(
  parameter int DATA_W = 64,
  parameter int LW     = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              crossed,
  input  logic              sub,
  input  logic [2:0]        policy,
  output logic [DATA_W-1:0] res,
  output logic              sat_any
);
  localparam int NL = DATA_W / LW;

  logic [NL-1:0] lane_sat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int PI = i ^ 1;
    logic [LW-1:0] b_sel;
    logic          l_sub;

    assign b_sel = crossed ? b[PI*LW +: LW] : b[i*LW +: LW];

    if (i % 2 == 1) begin : g_odd
      assign l_sub = sub;
    end else begin : g_even
      assign l_sub = crossed ? ~sub : sub;
    end

    psimd_lane #(.LW(LW)) u_lane (
      .a      (a[i*LW +: LW]),
      .b      (b_sel),
      .do_sub (l_sub),
      .policy (policy),
      .res    (res[i*LW +: LW]),
      .sat    (lane_sat[i])
    );
  end

  assign sat_any = |lane_sat;
endmodule

// File: rtl/psimd_addsub.sv
module psimd_addsub #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        elem_sz,
  input  logic              crossed,
  input  logic              sub,
  input  logic [2:0]        policy,
  input  logic              ovf_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ovf
);
  import psimd_pkg::*;

  logic [DATA_W-1:0] grp_res [NUM_SIZES];
  logic [NUM_SIZES-1:0] grp_sat;
  logic [DATA_W-1:0] sel_res;
  logic              sel_sat;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    psimd_group #(.DATA_W(DATA_W), .LW(8 << g)) u_grp (
      .a       (in_a),
      .b       (in_b),
      .crossed (crossed),
      .sub     (sub),
      .policy  (policy),
      .res     (grp_res[g]),
      .sat_any (grp_sat[g])
    );
  end

  always_comb begin
    unique case (elem_sz)
      2'd0:    begin sel_res = grp_res[0]; sel_sat = grp_sat[0]; end
      2'd1:    begin sel_res = grp_res[1]; sel_sat = grp_sat[1]; end
      default: begin sel_res = grp_res[2]; sel_sat = grp_sat[2]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_res;
      if (ovf_clr)                   out_ovf <= 1'b0;
      else if (in_valid && sel_sat)  out_ovf <= 1'b1;
    end
  end

  assert_valid_lat_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_lat_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_data_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (out_ovf && !ovf_clr) |=> out_ovf);
  assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_clr |=> !out_ovf);
endmodule

// File: tb/test_psimd_addsub.sv
module test_psimd_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  elem_sz = '0;
  logic        crossed = 1'b0, sub = 1'b0;
  logic [2:0]  policy = '0;
  logic        ovf_clr = 1'b0;
  logic        out_valid, out_ovf;
  logic [63:0] out_data;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  logic        m_valid = 1'b0, m_ovf = 1'b0;
  logic [63:0] m_data = '0;
  bit          done = 1'b0;

  always #4ns clk = ~clk;

  psimd_addsub i_psimd_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .elem_sz(elem_sz), .crossed(crossed), .sub(sub), .policy(policy),
    .ovf_clr(ovf_clr), .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf));

  function automatic logic [63:0] ref_calc(input logic [63:0] a, input logic [63:0] b,
      input logic [1:0] sz, input logic cr, input logic sb, input logic [2:0] pol,
      output bit satf);
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    int n = 64 / w;
    longint full = longint'(1) << w;
    longint half = full / 2;
    logic [63:0] acc = '0;
    int p = (pol > 4) ? 0 : int'(pol);
    bit sg = (p == 1) || (p == 3);
    satf = 0;
    for (int i = 0; i < n; i++) begin
      int bi = cr ? (i ^ 1) : i;
      bit opsub = cr ? ((i % 2 == 1) ? sb : !sb) : sb;
      longint av = longint'((a >> (i * w)) & 64'(full - 1));
      longint bv = longint'((b >> (bi * w)) & 64'(full - 1));
      longint r;
      if (sg && av >= half) av -= full;
      if (sg && bv >= half) bv -= full;
      r = opsub ? av - bv : av + bv;
      if (p == 1 || p == 2) r = r >>> 1;
      else if (p == 3) begin
        if (r > half - 1) begin r = half - 1; satf = 1; end
        if (r < -half)    begin r = -half;    satf = 1; end
      end else if (p == 4) begin
        if (r > full - 1) begin r = full - 1; satf = 1; end
        if (r < 0)        begin r = 0;        satf = 1; end
      end
      acc |= (64'(r) & 64'(full - 1)) << (i * w);
    end
    return acc;
  endfunction

  // behavioural model, advanced at every clock from the inputs
  always @(posedge clk) begin
    bit s;
    logic [63:0] r;
    if (rst) begin
      m_valid = 0; m_data = '0; m_ovf = 0;
    end else begin
      r = ref_calc(in_a, in_b, elem_sz, crossed, sub, policy, s);
      m_valid = in_valid;
      if (in_valid) m_data = r;
      if (ovf_clr) m_ovf = 0;
      else if (in_valid && s) m_ovf = 1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (out_valid !== m_valid || out_data !== m_data || out_ovf !== m_ovf) begin
        n_fail++;
        $display("FAIL %s: valid/data/ovf actual %b %h %b expected %b %h %b",
                 cur_req, out_valid, out_data, out_ovf, m_valid, m_data, m_ovf);
      end
    end
  end

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic cr, input logic sb, input logic [2:0] pol);
    @(negedge clk);
    in_valid = 1; in_a = a; in_b = b; elem_sz = sz; crossed = cr; sub = sb; policy = pol;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic direct(input string req, input logic [63:0] exp_d);
    n_chk++;
    if (out_data !== exp_d) begin
      n_fail++;
      $display("FAIL %s: data actual %h expected %h", req, out_data, exp_d);
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R10";
    @(negedge clk);
    n_chk++;
    if (out_valid !== 0 || out_data !== 0 || out_ovf !== 0) begin
      n_fail++;
      $display("FAIL R10: actual %b %h %b expected 0 0 0", out_valid, out_data, out_ovf);
    end
    cur_req = "R1";
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 0, 0, 3'd0);
    direct("R1", 64'h0);
    drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 0, 0, 3'd0);
    direct("R1", 64'h0);
    cur_req = "R2";
    drive(64'h7FFF_FFFF_1234_5678, 64'h0000_0001_1111_1111, 2'd2, 0, 0, 3'd6);
    direct("R2", 64'h8000_0000_2345_6789);
    cur_req = "R3";
    drive(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0003, 2'd2, 0, 1, 3'd1);
    direct("R3", 64'hFFFF_FFFF_FFFF_FFFE);
    drive(64'h00FF, 64'h00FF, 2'd1, 0, 0, 3'd2);
    direct("R3", 64'h00FF);
    cur_req = "R4";
    drive(64'h0, 64'h8000_8000_8000_8000, 2'd1, 0, 1, 3'd3);
    direct("R4", 64'h7FFF_7FFF_7FFF_7FFF);
    cur_req = "R9";
    @(negedge clk);
    n_chk++;
    if (out_ovf !== 1) begin n_fail++; $display("FAIL R9: ovf actual %b expected 1", out_ovf); end
    @(negedge clk); in_valid = 1; in_a = '0; in_b = 64'h80; elem_sz = 0; sub = 1; policy = 3; ovf_clr = 1;
    @(negedge clk); in_valid = 0; ovf_clr = 0;
    n_chk++;
    if (out_ovf !== 0) begin n_fail++; $display("FAIL R9: ovf actual %b expected 0", out_ovf); end
    cur_req = "R5";
    drive(64'hF0, 64'h20, 2'd0, 0, 0, 3'd4);
    direct("R5", 64'hFF);
    drive(64'h10, 64'h20, 2'd0, 0, 1, 3'd4);
    direct("R5", 64'h00);
    cur_req = "R6";
    drive(64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101, 2'd0, 0, 1, 3'd0);
    direct("R6", 64'h0001_0203_0405_0607);
    cur_req = "R7";
    drive(64'h0000_0010_0000_0020, 64'h0000_0001_0000_0005, 2'd2, 1, 0, 3'd0);
    direct("R7", 64'h0000_0015_0000_001F);
    drive(64'h0000_0010_0000_0020, 64'h0000_0001_0000_0005, 2'd2, 1, 1, 3'd0);
    direct("R7", 64'h0000_000B_0000_0021);
    cur_req = "R8";
    @(negedge clk); in_a = '1; in_b = '1; policy = 0;
    repeat (3) @(negedge clk);
    direct("R8", 64'h0000_000B_0000_0021);
    for (int k = 0; k < 600; k++) begin
      cur_req = (k % 2 == 0) ? "R7" : "R3";
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
      if (k % 5 == 0) in_b = {4{16'h8000}};
      elem_sz = 2'($urandom); crossed = 1'($urandom); sub = 1'($urandom);
      policy = 3'($urandom); ovf_clr = ($urandom % 16) == 0;
    end
    @(negedge clk); in_valid = 0; ovf_clr = 0;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule